// File: doc/BRIEF.md
# Command-Driven Random Number Register Front-End

This block is the software-facing half of a hardware random number generator. A processor drives it over a plain 32-bit register bus with one-cycle access. The bus has an address, a write enable, write data and combinational read data. Software writes a command code to start work. One command seeds the generator and another produces a fresh 128-bit result. Completion is reported through sticky flags, which software clears by writing ones. A single interrupt line follows those flags through a per-flag enable mask.

The physical noise source sits outside the block. Raw bits arrive one per cycle on `entBit`, qualified by `entValid`, and the block takes a bit only while it is seeding or generating. Seeding shifts 128 bits into a private state register. Generating shifts 128 further bits, and at the end the collected value, XOR-ed with the seed state, is copied into four readable 32-bit words. If software asks for random data before any seed exists, the block first runs the seed phase without being asked, then generates.

Register offsets, in bytes:
- 0x00: command.
- 0x04: status. Bit 0 is busy, bit 9 is seeded.
- 0x08: result width. 0 selects 128 bits.
- 0x10: interrupt enable.
- 0x14: event flags. Bit 0 is result ready, bit 1 is seed done.
- 0x20, 0x24, 0x28, 0x2C: result words.

Every other offset reads zero.

Top module: `rngCmdFront`

## Requirements
- R1: After reset, status, event flags and all four result words read 0, and `irqOut` is low.
- R2: Writing command code 2 makes status bit 0 read 1 until 128 valid bits have been taken. After that, status bit 9 reads 1 and stays 1, and event flag bit 1 is set.
- R3: Writing command code 1 to a seeded block collects 128 valid bits, the first received becoming bit 127 and the last becoming bit 0. It then sets event flag bit 0, and the result words show that value XOR the seed state, with the word at offset 0x20+4*i holding bits [32*i+31 : 32*i].
- R4: A cycle with `entValid` low takes no bit and does not advance the phase.
- R5: Command code 1 on an unseeded block runs a full 128-bit seed phase, setting flag bit 1 and keeping busy high, and then a 128-bit generation phase.
- R6: A command written while busy is ignored, and the running phase finishes unchanged.
- R7: Writing a 1 to an event flag bit clears it, writing 0 leaves it, and writing all ones clears every flag.
- R8: If a phase completes in the same cycle as a clearing write to its own flag, the flag ends set.
- R9: `irqOut` is high exactly when some event flag is set together with its enable bit (enable bit 0 for ready, bit 1 for seed done), so an enable of 0 keeps it low.
- R10: The result words hold their value during a later generation until that generation completes.
- R11: Command code 0 has no effect, and the enable and width registers read back the value written (two bits each).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address of the register access |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| entBit | input | 1 | Raw noise bit |
| entValid | input | 1 | Qualifies `entBit` for this cycle |
| irqOut | output | 1 | Interrupt request |

## Verification
Two functions can land on the same edge: a phase completing sets its event flag, and software writes ones to that same flag to clear it. The bench arranges this by driving the 128th noise bit of a generation in the same cycle as a write of 1 to the ready flag. It then expects the ready flag still set and the new result words present. A second collision is a command written in the middle of a generation, which must leave both the result and the bit count untouched.

// File: rtl/rngFrontPkg.sv
package rngFrontPkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SEED = 2'd1,
    PH_GEN  = 2'd2
  } phaseT;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic takeSeed;
    logic takeGen;
  } strobeT;

  localparam logic [1:0] CMD_NOP  = 2'd0;
  localparam logic [1:0] CMD_GEN  = 2'd1;
  localparam logic [1:0] CMD_SEED = 2'd2;

  localparam int OFF_CMD   = 'h00;
  localparam int OFF_STAT  = 'h04;
  localparam int OFF_WIDTH = 'h08;
  localparam int OFF_IEN   = 'h10;
  localparam int OFF_FLAGS = 'h14;
  localparam int OFF_OUT   = 'h20;

  localparam int FLAG_RDY    = 0;
  localparam int FLAG_SEEDED = 1;
  localparam int STAT_BUSY   = 0;
  localparam int STAT_SEEDED = 9;

endpackage

// File: rtl/rngDatapath.sv
module rngDatapath
  import rngFrontPkg::*;
#(
  parameter int ENT_BITS = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strb,
  input  logic                entBit,
  input  logic                entValid,
  output logic                lastBit,
  output logic [ENT_BITS-1:0] outWords
);

  localparam int CNT_W = $clog2(ENT_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ENT_BITS - 1);

  logic [CNT_W-1:0]    bitCnt;
  logic [ENT_BITS-1:0] seedState;
  logic [ENT_BITS-1:0] genShift;
  logic                accept;

  assign accept  = (strb.takeSeed | strb.takeGen) & entValid;
  assign lastBit = accept && (bitCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      seedState <= '0;
      genShift  <= '0;
      outWords  <= '0;
    end else begin
      if (accept) begin
        bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
      end
      if (strb.takeSeed && entValid) begin
        seedState <= {seedState[ENT_BITS-2:0], entBit};
      end
      if (strb.takeGen && entValid) begin
        genShift <= {genShift[ENT_BITS-2:0], entBit};
      end
      if (strb.takeGen && lastBit) begin
        outWords <= {genShift[ENT_BITS-2:0], entBit} ^ seedState;
      end
    end
  end

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !entValid |=> $stable(bitCnt));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.takeGen && lastBit) |=> $stable(outWords));

endmodule

// File: rtl/rngControl.sv
module rngControl
  import rngFrontPkg::*;
#(
  parameter int ENT_BITS = 128,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic                lastBit,
  input  logic [ENT_BITS-1:0] outWords,
  output strobeT              strb,
  output logic                irqOut
);

  localparam int NUM_WORDS = ENT_BITS / DATA_W;

  phaseT      phase;
  logic       pendGen;
  logic       seeded;
  logic [1:0] flags;
  logic [1:0] ieReg;
  logic [1:0] widthReg;
  logic       cmdWr;
  logic [1:0] cmdCode;
  logic [1:0] setMask;
  logic [1:0] clrMask;
  logic       unusedBits;

  assign unusedBits = ^busWdata[DATA_W-1:2];
  assign cmdWr   = busWe && (busAddr == ADDR_W'(OFF_CMD));
  assign cmdCode = busWdata[1:0];

  assign setMask[FLAG_RDY]    = (phase == PH_GEN)  && lastBit;
  assign setMask[FLAG_SEEDED] = (phase == PH_SEED) && lastBit;
  assign clrMask = (busWe && busAddr == ADDR_W'(OFF_FLAGS)) ? busWdata[1:0] : 2'b00;

  assign strb.takeSeed = (phase == PH_SEED);
  assign strb.takeGen  = (phase == PH_GEN);
  assign irqOut        = |(flags & ieReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      pendGen  <= 1'b0;
      seeded   <= 1'b0;
      flags    <= '0;
      ieReg    <= '0;
      widthReg <= '0;
    end else begin
      flags <= (flags & ~clrMask) | setMask;
      if (busWe && busAddr == ADDR_W'(OFF_IEN))   ieReg    <= busWdata[1:0];
      if (busWe && busAddr == ADDR_W'(OFF_WIDTH)) widthReg <= busWdata[1:0];
      case (phase)
        PH_IDLE: begin
          if (cmdWr && cmdCode == CMD_GEN) begin
            if (seeded) begin
              phase <= PH_GEN;
            end else begin
              phase   <= PH_SEED;
              pendGen <= 1'b1;
            end
          end else if (cmdWr && cmdCode == CMD_SEED) begin
            phase   <= PH_SEED;
            pendGen <= 1'b0;
          end
        end
        PH_SEED: begin
          if (lastBit) begin
            seeded  <= 1'b1;
            pendGen <= 1'b0;
            phase   <= pendGen ? PH_GEN : PH_IDLE;
          end
        end
        PH_GEN: begin
          if (lastBit) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(OFF_STAT)) begin
      busRdata[STAT_BUSY]   = (phase != PH_IDLE);
      busRdata[STAT_SEEDED] = seeded;
    end else if (busAddr == ADDR_W'(OFF_WIDTH)) begin
      busRdata[1:0] = widthReg;
    end else if (busAddr == ADDR_W'(OFF_IEN)) begin
      busRdata[1:0] = ieReg;
    end else if (busAddr == ADDR_W'(OFF_FLAGS)) begin
      busRdata[1:0] = flags;
    end
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (busAddr == ADDR_W'(OFF_OUT + 4 * i)) busRdata = outWords[i*DATA_W +: DATA_W];
    end
  end

  // R2
  seeded_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    seeded |=> seeded);

  // R3
  rdy_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[FLAG_RDY]) |-> $past(phase == PH_GEN));

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && !lastBit) |=> (phase == $past(phase)));

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ieReg == 2'b00) |-> !irqOut);

endmodule

// File: rtl/rngCmdFront.sv
module rngCmdFront
  import rngFrontPkg::*;
#(
  parameter int ENT_BITS = 128,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              entBit,
  input  logic              entValid,
  output logic              irqOut
);

  strobeT              strb;
  logic                lastBit;
  logic [ENT_BITS-1:0] outWords;

  rngControl #(.ENT_BITS(ENT_BITS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .lastBit  (lastBit),
    .outWords (outWords),
    .strb     (strb),
    .irqOut   (irqOut)
  );

  rngDatapath #(.ENT_BITS(ENT_BITS)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .entBit   (entBit),
    .entValid (entValid),
    .lastBit  (lastBit),
    .outWords (outWords)
  );

endmodule

// File: tb/tb_rngCmdFront.sv
module tb_rngCmdFront;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [7:0]  rdAddr = '0;
  logic [7:0]  busAddr;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        entBit = 1'b0;
  logic        entValid = 1'b0;
  logic        irqOut;

  int tests = 0;
  int fails = 0;
  int pending = 0;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } itemT;
  itemT expQ[$];

  assign busAddr = busWe ? wrAddr : rdAddr;

  always #2 clk = ~clk;

  rngCmdFront dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .entBit(entBit),
    .entValid(entValid), .irqOut(irqOut)
  );

  // Monitor: pops expected reads and compares
  initial begin
    itemT it;
    forever begin
      wait (pending > 0);
      @(negedge clk);
      it = expQ.pop_front();
      rdAddr = it.addr;
      #1;
      tests++;
      if (busRdata !== it.exp) begin
        fails++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, busRdata, it.exp);
      end
      pending--;
    end
  end

  task automatic expectRd(input logic [7:0] a, input logic [31:0] e, input string tag);
    expQ.push_back('{a, e, tag});
    pending++;
  endtask

  task automatic sync();
    wait (pending == 0);
    @(negedge clk);
  endtask

  task automatic chkIrq(input logic e, input string tag);
    tests++;
    if (irqOut !== e) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irqOut, e);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic feed(input logic [127:0] v, input int n, input int gapEvery);
    for (int i = 0; i < n; i++) begin
      if (gapEvery > 0 && (i % gapEvery) == gapEvery - 1) begin
        entValid = 1'b0; entBit = 1'b1;
        @(negedge clk);
      end
      entValid = 1'b1; entBit = v[127-i];
      @(negedge clk);
    end
    entValid = 1'b0;
  endtask

  task automatic expectWords(input logic [127:0] v, input string tag);
    for (int i = 0; i < 4; i++) expectRd(8'h20 + 8'(4*i), v[32*i +: 32], tag);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  localparam logic [127:0] S1 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
  localparam logic [127:0] G1 = 128'hA5A5_5A5A_F00F_0FF0_1357_9BDF_2468_ACE0;
  localparam logic [127:0] G2 = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
  localparam logic [127:0] G3 = 128'hDEAD_BEEF_CAFE_F00D_0BAD_C0DE_1234_5678;
  localparam logic [127:0] S2 = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
  localparam logic [127:0] G4 = 128'h9999_AAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0001;

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    expectRd(8'h04, 32'h0, "R1 status");
    expectRd(8'h14, 32'h0, "R1 flags");
    expectWords(128'h0, "R1 words");
    sync();
    chkIrq(1'b0, "R1");

    // R11 register readback and no-op command
    wr(8'h10, 32'h0);
    wr(8'h08, 32'h2);
    expectRd(8'h08, 32'h2, "R11 width readback");
    sync();
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h0);
    expectRd(8'h04, 32'h0, "R11 nop status");
    expectRd(8'h10, 32'h0, "R11 enable readback");
    sync();

    // R2 seed with R4 gaps
    wr(8'h00, 32'h2);
    expectRd(8'h04, 32'h1, "R2 busy");
    expectRd(8'h04, 32'h1, "R4 no bits no progress");
    sync();
    feed(S1, 128, 5);
    expectRd(8'h04, 32'h200, "R2 seeded");
    expectRd(8'h14, 32'h2, "R2 seed flag");
    sync();
    chkIrq(1'b0, "R9 masked");

    // R9 enable and R7 clears
    wr(8'h10, 32'h2);
    chkIrq(1'b1, "R9 enabled");
    wr(8'h14, 32'h1);
    expectRd(8'h14, 32'h2, "R7 zero bit leaves flag");
    sync();
    wr(8'h14, 32'h2);
    expectRd(8'h14, 32'h0, "R7 one clears");
    sync();
    chkIrq(1'b0, "R9 after clear");

    // R3 generate with R6 command mid-run
    wr(8'h00, 32'h1);
    feed(G1, 64, 0);
    wr(8'h00, 32'h2);
    expectRd(8'h04, 32'h201, "R6 still busy");
    sync();
    feed(G1 << 64, 64, 0);
    expectRd(8'h04, 32'h200, "R6 finished normally");
    expectRd(8'h14, 32'h1, "R3 ready flag");
    expectWords(G1 ^ S1, "R3 words");
    sync();
    wr(8'h14, 32'hFFFF_FFFF);
    expectRd(8'h14, 32'h0, "R7 all ones");
    sync();

    // R10 hold during next generation
    wr(8'h00, 32'h1);
    feed(G2, 100, 0);
    expectWords(G1 ^ S1, "R10 hold");
    sync();
    feed(G2 << 100, 28, 0);
    expectWords(G2 ^ S1, "R10 update");
    sync();

    // R8 completion coinciding with clear of ready flag
    wr(8'h14, 32'h3);
    wr(8'h00, 32'h1);
    feed(G3, 127, 0);
    entValid = 1'b1; entBit = G3[0];
    wrAddr = 8'h14; busWdata = 32'h1; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; entValid = 1'b0;
    expectRd(8'h14, 32'h1, "R8 set wins");
    expectWords(G3 ^ S1, "R8 words");
    sync();

    // R5 implicit seed after reset
    doReset();
    wr(8'h10, 32'h1);
    wr(8'h00, 32'h1);
    expectRd(8'h04, 32'h1, "R5 busy unseeded");
    sync();
    feed(S2, 128, 0);
    expectRd(8'h04, 32'h201, "R5 still busy after seed");
    expectRd(8'h14, 32'h2, "R5 seed flag");
    sync();
    chkIrq(1'b0, "R9 seed flag masked");
    feed(G4, 128, 7);
    expectRd(8'h04, 32'h200, "R5 done");
    expectRd(8'h14, 32'h3, "R5 both flags");
    expectWords(G4 ^ S2, "R5 words");
    sync();
    chkIrq(1'b1, "R9 ready enabled");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule